// File: doc/BRIEF.md
# Boot-Aware Chip-Select Decoder

This block turns the address of an external bus access into one of up to eight active-low select strobes. Each select has a base address, an address mask and a valid flag. It also has a control word that sets its port width, whether the block acknowledges the transfer itself, and how many wait states to insert first. Along with the select, the block reports which byte lanes of the 32-bit data bus the addressed device uses. If automatic acknowledge is on, it also produces a one-cycle transfer acknowledge once the wait count has run out.

Select 0 is the boot select. Until software sets its valid flag, it fires for every external access at any address, and no other select can fire. This lets a boot memory answer before any decode registers are set up. Three data-bus pins are strapped at reset and give select 0 its starting port width and its acknowledge behaviour.

Top module: `cs_decoder`

## Requirements
- R1: With `acc_req` low, every bit of `cs_n` is high and `lane_en` is 0. After reset, `ta` is low and no select is valid.
- R2: While select 0 is not valid, any access with `acc_req` high drives `cs_n[0]` low, whatever the address.
- R3: While select 0 is not valid, `cs_n[7:1]` stay high, even if selects 1 to 7 are programmed and marked valid.
- R4: Once select 0 is valid, select i matches when its valid flag is set and `((acc_addr[31:16] ^ base_i) & ~mask_i) == 0`. A mask bit of 1 makes that address bit a don't-care. Only a matching select may go low.
- R5: When several selects match, only the lowest-numbered one goes low. When none match, all stay high.
- R6: On the first clock edge after reset is released, `strap_d[2]` sets the boot acknowledge. A value of 0 means no automatic acknowledge. A value of 1 means acknowledge after 15 wait states, so `ta` first appears 17 falling edges after the access is driven.
- R7: On that same edge, `strap_d[1:0]` sets the boot port width. 00 is 32-bit, 01 is 8-bit, and 10 or 11 is 16-bit.
- R8: `lane_en` bit 3 stands for D[31:24] and bit 0 for D[7:0]. A 32-bit select gives 1111, an 8-bit one gives 1000 and a 16-bit one gives 1100. This follows the port width of the winning select, coded as in R7.
- R9: If the winning select has automatic acknowledge and a wait count W, `ta` goes high for exactly one cycle, W+1 clock edges after the edge where the access starts. The requester drops `acc_req` while `ta` is high.
- R10: Changes on `strap_d` after that first edge have no effect.
- R11: A write takes effect on a clock edge when `reg_we` is high. `reg_addr[4:2]` picks the select and `reg_addr[1:0]` picks the word: 0 is the base, 1 is the mask, 2 is control and 3 is the valid flag (`reg_wdata[0]`). The control word holds the port width in bits 1:0, automatic acknowledge in bit 2 and the wait count in bits 6:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_d | input | 3 | Boot straps: acknowledge enable, port width [1:0] |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Select index and word index |
| reg_wdata | input | 16 | Register write data |
| acc_req | input | 1 | External access in progress |
| acc_addr | input | 32 | Access address |
| cs_n | output | 8 | Active-low select strobes |
| lane_en | output | 4 | Byte lanes used by the winning select |
| ta | output | 1 | Transfer acknowledge pulse |

## Verification
The hardest case to reach is the gating in boot mode: selects 1 to 7 hold addresses that would match and are marked valid, yet they must stay silent. The bench sets up exactly that case before it turns on select 0. It then sweeps every value of the top address byte over a layout with overlapping windows and one invalid select, so that priority and the don't-care mask bits are both exercised. The straps are swept over all eight values, and each one gets its own reset.

// File: rtl/cs_decoder.sv
module cs_decoder #(
  parameter int N_SEL     = 8,
  parameter int AW        = 32,
  parameter int BW        = 16,
  parameter int WW        = 4,
  parameter int BOOT_WAIT = 15
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2:0]                 strap_d,
  input  logic                       reg_we,
  input  logic [$clog2(N_SEL)+1:0]   reg_addr,
  input  logic [BW-1:0]              reg_wdata,
  input  logic                       acc_req,
  input  logic [AW-1:0]              acc_addr,
  output logic [N_SEL-1:0]           cs_n,
  output logic [3:0]                 lane_en,
  output logic                       ta
);
  localparam int SW  = $clog2(N_SEL);
  localparam int RAW = SW + 2;

  logic [BW-1:0] base_q [N_SEL];
  logic [BW-1:0] mask_q [N_SEL];
  logic [1:0]    ps_q   [N_SEL];
  logic [WW-1:0] ws_q   [N_SEL];
  logic [N_SEL-1:0] vld_q, aa_q, hit;
  logic          strap_done;
  logic [BW-1:0] addr_hi;
  logic [SW-1:0] win;
  logic          any, busy, start;
  logic [WW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) strap_done <= 1'b0;
    else        strap_done <= 1'b1;

  for (genvar i = 0; i < N_SEL; i++) begin : g_sel
    wire wsel = reg_we && (reg_addr[RAW-1:2] == SW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[i] <= '0;
        mask_q[i] <= '0;
        ps_q[i]   <= '0;
        ws_q[i]   <= '0;
        aa_q[i]   <= 1'b0;
        vld_q[i]  <= 1'b0;
      end else if (i == 0 && !strap_done) begin
        aa_q[i] <= strap_d[2];
        ps_q[i] <= strap_d[1:0];
        ws_q[i] <= WW'(BOOT_WAIT);
      end else if (wsel) begin
        case (reg_addr[1:0])
          2'd0: base_q[i] <= reg_wdata;
          2'd1: mask_q[i] <= reg_wdata;
          2'd2: begin
            ps_q[i] <= reg_wdata[1:0];
            aa_q[i] <= reg_wdata[2];
            ws_q[i] <= reg_wdata[WW+2:3];
          end
          default: vld_q[i] <= reg_wdata[0];
        endcase
      end
    end
    assign hit[i] = vld_q[i] && vld_q[0] && (((addr_hi ^ base_q[i]) & ~mask_q[i]) == '0);
  end

  assign addr_hi = acc_addr[AW-1:AW-BW];

  always_comb begin
    win = '0;
    any = 1'b0;
    if (!vld_q[0]) begin
      any = 1'b1;
    end else begin
      for (int i = N_SEL - 1; i >= 0; i--)
        if (hit[i]) begin
          win = SW'(i);
          any = 1'b1;
        end
    end
  end

  wire active = acc_req && any;
  assign cs_n = active ? ~(N_SEL'(1) << win) : '1;

  always_comb begin
    if (!active)            lane_en = 4'b0000;
    else if (ps_q[win] == 2'b00) lane_en = 4'b1111;
    else if (ps_q[win] == 2'b01) lane_en = 4'b1000;
    else                    lane_en = 4'b1100;
  end

  assign start = active && aa_q[win] && !busy && !ta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      ta   <= 1'b0;
    end else begin
      ta <= 1'b0;
      if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          ta   <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (start) begin
        busy <= 1'b1;
        cnt  <= ws_q[win];
      end
    end
  end

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_req |-> (&cs_n) && (lane_en == 4'b0000));
  p_boot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !vld_q[0]) |-> !cs_n[0]);
  p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q[0] |-> (&cs_n[N_SEL-1:1]));
  p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ta |=> !ta);
  p_ta_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ta |-> $past(busy) && ($past(cnt) == '0));
  p_strap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strap_done) |-> (ps_q[0] == $past(strap_d[1:0])) && (aa_q[0] == $past(strap_d[2])));
endmodule

// File: tb/test_cs_decoder.sv
`timescale 1ns/1ps
module test_cs_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  strap_d = 3'b000;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        acc_req = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [7:0]  cs_n;
  logic [3:0]  lane_en;
  logic        ta;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [15:0] mb [8];
  logic [15:0] mm [8];
  logic [1:0]  mps [8];
  logic        mv [8];

  always #10 clk = ~clk;

  cs_decoder i_cs_decoder (
    .clk(clk), .rst_n(rst_n), .strap_d(strap_d), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .acc_req(acc_req),
    .acc_addr(acc_addr), .cs_n(cs_n), .lane_en(lane_en), .ta(ta));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] lanes(input logic [1:0] ps);
    return (ps == 2'b00) ? 4'b1111 : (ps == 2'b01) ? 4'b1000 : 4'b1100;
  endfunction

  task automatic wr(input int sel, input int fld, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'((sel << 2) | fld); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic do_reset(input logic [2:0] s);
    @(negedge clk);
    rst_n = 1'b0; strap_d = s; acc_req = 1'b0;
    repeat (2) @(negedge clk);
    #1 chk(cs_n == 8'hFF && lane_en == 4'h0 && ta == 1'b0, "R1 reset", {cs_n, lane_en, 3'b0, ta}, 32'hFF00);
    rst_n = 1'b1;
    @(negedge clk);
    strap_d = ~s;
  endtask

  task automatic access_ta(input logic [31:0] a, input int exp_k, input string req);
    int got = 0;
    @(negedge clk);
    acc_req = 1'b1; acc_addr = a;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (ta) begin got = k; break; end
    end
    chk(got == exp_k, req, got, exp_k);
    acc_req = 1'b0;
    @(negedge clk);
    chk(ta == 1'b0 && cs_n == 8'hFF, {req, " pulse"}, {cs_n, 3'b0, ta}, 32'hFF0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R6 R7 R10: every strap value, boot select answers all addresses
    for (int s = 0; s < 8; s++) begin
      do_reset(3'(s));
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        acc_req = 1'b1; acc_addr = 32'h1111_1111 * k;
        #1;
        chk(cs_n == 8'hFE, "R2 boot select", cs_n, 8'hFE);
        chk(lane_en == lanes(2'(s)), "R7 boot width", lane_en, lanes(2'(s)));
      end
      acc_req = 1'b0;
      repeat (20) @(negedge clk);
      access_ta(32'hDEAD_0000, s[2] ? 17 : 0, "R6 boot ack R10");
    end

    // R3: other selects programmed and valid, select 0 still booting
    do_reset(3'b001);
    for (int i = 1; i < 8; i++) begin
      wr(i, 0, 16'h0000); wr(i, 1, 16'hFFFF); wr(i, 2, 16'h0000); wr(i, 3, 16'h0001);
    end
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      acc_req = 1'b1; acc_addr = {k[5:0], 26'h15A_5A5A};
      #1;
      chk(cs_n == 8'hFE, "R3 gated", cs_n, 8'hFE);
      chk(lane_en == 4'b1000, "R3 lanes", lane_en, 4'b1000);
    end
    acc_req = 1'b0;

    // R4 R5 R8 R11: overlapping layout, select 6 invalid
    for (int i = 0; i < 8; i++) begin
      mb[i] = 16'(i * 16'h2000);
      mm[i] = (i % 2) ? 16'h3FFF : 16'h1FFF;
      mps[i] = 2'(i % 3);
      mv[i] = (i != 6);
      wr(i, 0, mb[i]); wr(i, 1, mm[i]);
      wr(i, 2, {9'd0, (i == 1) ? 4'd3 : 4'd0, (i == 1 || i == 2), mps[i]});
      if (i != 0) wr(i, 3, {15'd0, mv[i]});
    end
    wr(0, 3, 16'h0001);
    for (int k = 0; k < 256; k++) begin
      logic [15:0] ah;
      logic [7:0] ecs;
      logic [3:0] el;
      int w;
      ah = {k[7:0], 8'h5A};
      w = -1;
      for (int i = 7; i >= 0; i--)
        if (mv[i] && (((ah ^ mb[i]) & ~mm[i]) == 16'h0)) w = i;
      ecs = (w < 0) ? 8'hFF : ~(8'h01 << w);
      el = (w < 0) ? 4'h0 : lanes(mps[w]);
      @(negedge clk);
      acc_req = 1'b1; acc_addr = {ah, 16'h1234};
      #1;
      chk(cs_n == ecs, "R4 R5 decode", cs_n, ecs);
      chk(lane_en == el, "R8 lanes", lane_en, el);
    end
    acc_req = 1'b0;
    repeat (20) @(negedge clk);

    // R9: programmed wait counts, R1 idle
    #1 chk(cs_n == 8'hFF && lane_en == 4'h0, "R1 idle", {cs_n, lane_en}, 12'hFF0);
    access_ta(32'h2100_0000, 5, "R9 wait 3");
    access_ta(32'h4100_0000, 2, "R9 wait 0");
    access_ta(32'h0100_0000, 0, "R9 no ack");
    wr(1, 2, {9'd0, 4'd7, 1'b1, 2'b10});
    access_ta(32'h2100_0000, 9, "R9 wait 7 R11");
    @(negedge clk);
    acc_req = 1'b1; acc_addr = 32'hD000_0000;
    #1 chk(cs_n == 8'h7F, "R5 invalid falls through", cs_n, 8'h7F);
    acc_req = 1'b0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule